// File: doc/BRIEF.md
# MAC Address Hash Filter

This block makes the accept decision for received frames from their 48-bit destination address. The address is reduced to a 12-bit hash index by picking a 12-bit window out of its upper 16 bits. The index selects one bit in one of two 4096-bit tables. Group addresses use the multicast table and individual addresses use the unicast table. A 2-bit mode picks the window, and the two tables share it. Each table has its own enable, and a separate control decides whether the all-ones broadcast address is accepted.

Software loads the tables one 32-bit word at a time. Each table is 128 words deep. A fill command writes every word of one table with all ones or all zeros, one word per clock. Software uses it to accept every unicast address, or to clear a table before loading it. Lookups are pipelined, and one result comes out on the cycle after each address strobe.

Top module: `mac_hash_filter`

## Requirements
- R1: The hash index is a 12-bit window of the address. Address bit n is `lk_addr[n]`. Mode 0 takes bits 47:36, mode 1 takes bits 46:35, mode 2 takes bits 45:34 and mode 3 takes bits 43:32, with the highest address bit as the index MSB.
- R2: Index bits [11:5] select the table word (`cfg_wr_idx` value) and index bits [4:0] select the bit within that word. Bit 0 is `cfg_wr_data[0]`.
- R3: An address with `lk_addr[0]`=1 is a group address and is looked up in the multicast table (`cfg_wr_sel`=0). Any other address is looked up in the unicast table (`cfg_wr_sel`=1). `res_multicast` reports `lk_addr[0]` of the looked-up address.
- R4: While a table's enable (`cfg_mc_en` or `cfg_uc_en`) is 0, a lookup routed to that table is rejected, whatever the table holds.
- R5: The all-ones address is accepted exactly when `cfg_bc_accept` is 1, independent of the multicast table and of `cfg_mc_en`.
- R6: `res_valid` is high exactly in the cycle after a cycle with `lk_valid` high. `res_accept` is 0 whenever `res_valid` is 0.
- R7: A word written with `cfg_wr_en` is seen by lookups strobed from the next cycle on. A lookup strobed in the same cycle as a write to its word sees the old contents.
- R8: A `cfg_fill_start` pulse while idle makes `fill_busy` go high on the next cycle for exactly 128 cycles. During those cycles every word of the table chosen by `cfg_wr_sel` at the pulse is written with all ones (`cfg_fill_ones`=1) or all zeros. Software writes and fill pulses that arrive while `fill_busy` is high are dropped.
- R9: After reset, `res_valid`, `res_accept`, `res_multicast` and `fill_busy` are 0. The table contents are undefined until software writes them.
- R10: The mode, the enables and the broadcast control are sampled in the strobe cycle. Changing them in the following cycle does not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Hash window select |
| cfg_mc_en | input | 1 | Multicast table enable |
| cfg_uc_en | input | 1 | Unicast table enable |
| cfg_bc_accept | input | 1 | Accept the all-ones address |
| cfg_wr_en | input | 1 | Table word write strobe |
| cfg_wr_sel | input | 1 | Table select: 0 multicast, 1 unicast |
| cfg_wr_idx | input | 7 | Table word index |
| cfg_wr_data | input | 32 | Table word data |
| cfg_fill_start | input | 1 | Start a whole-table fill |
| cfg_fill_ones | input | 1 | Fill value: 1 all ones, 0 all zeros |
| fill_busy | output | 1 | Fill in progress |
| lk_valid | input | 1 | Lookup address strobe |
| lk_addr | input | 48 | Destination address; byte 0 in bits 7:0 |
| res_valid | output | 1 | Lookup result valid |
| res_accept | output | 1 | Frame accepted |
| res_multicast | output | 1 | Looked-up address was a group address |

## Verification
A corrupted table bit has no effect until an address hashes onto it. The bench therefore writes random words into both tables and looks up random addresses under changing modes. A stale or misplaced bit then shows up as a wrong `res_accept` one cycle after the strobe. A wrong window or word/bit split also fails there, and so does a read that sees a same-cycle write. A fill pointer that stops early or writes the wrong table is only visible on later lookups, so lookups run during and after each fill. `fill_busy` is compared every cycle, so its length is checked exactly.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam int ADDR_W   = 48;
  localparam int HI_LSB   = 32;
  localparam int HI_W     = ADDR_W - HI_LSB;
  localparam int HASH_W   = 12;
  localparam int N_TABLES = 2;

  localparam int TBL_MC = 0;
  localparam int TBL_UC = 1;

  typedef enum logic [1:0] {
    WIN_47_36 = 2'd0,
    WIN_46_35 = 2'd1,
    WIN_45_34 = 2'd2,
    WIN_43_32 = 2'd3
  } hash_win_e;

  typedef struct packed {
    logic is_bc;
    logic is_grp;
    logic mc_en;
    logic uc_en;
    logic bc_acc;
  } lk_ctx_t;

endpackage

// File: rtl/mhf_index.sv
module mhf_index
  import mhf_pkg::*;
(
  input  logic [HI_W-1:0]   addr_hi,
  input  logic [1:0]        mode,
  output logic [HASH_W-1:0] idx
);

  always_comb begin
    unique case (hash_win_e'(mode))
      WIN_47_36: idx = addr_hi[HI_W-1 -: HASH_W];
      WIN_46_35: idx = addr_hi[HI_W-2 -: HASH_W];
      WIN_45_34: idx = addr_hi[HI_W-3 -: HASH_W];
      default:   idx = addr_hi[HASH_W-1:0];
    endcase
  end

endmodule

// File: rtl/mhf_table.sv
module mhf_table #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int PTR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [WORDS];

  // Single clocked process, non-blocking: a read of the word being
  // written returns the old value (read-first block RAM).
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/mhf_fill.sv
module mhf_fill #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int PTR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ones,
  input  logic              sel_in,
  output logic              busy,
  output logic              sel,
  output logic [PTR_W-1:0]  ptr,
  output logic [WORD_W-1:0] data
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(WORDS - 1);

  logic ones_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      ptr    <= '0;
      sel    <= 1'b0;
      ones_q <= 1'b0;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) busy <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      ptr    <= '0;
      sel    <= sel_in;
      ones_q <= ones;
    end
  end

  assign data = {WORD_W{ones_q}};

endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter
  import mhf_pkg::*;
#(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int PTR_W = $clog2(WORDS),
  localparam int BIT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_mc_en,
  input  logic              cfg_uc_en,
  input  logic              cfg_bc_accept,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_sel,
  input  logic [PTR_W-1:0]  cfg_wr_idx,
  input  logic [WORD_W-1:0] cfg_wr_data,
  input  logic              cfg_fill_start,
  input  logic              cfg_fill_ones,
  output logic              fill_busy,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_multicast
);

  // ---------------- hash index ----------------
  logic [HASH_W-1:0] hidx;
  logic [PTR_W-1:0]  rd_word;
  logic [BIT_W-1:0]  rd_bit;

  mhf_index u_index (
    .addr_hi (lk_addr[ADDR_W-1:HI_LSB]),
    .mode    (cfg_mode),
    .idx     (hidx)
  );

  assign rd_word = hidx[BIT_W +: PTR_W];
  assign rd_bit  = hidx[BIT_W-1:0];

  // ---------------- fill sequencer ----------------
  logic              fl_sel;
  logic [PTR_W-1:0]  fl_ptr;
  logic [WORD_W-1:0] fl_data;

  mhf_fill #(.WORDS(WORDS), .WORD_W(WORD_W)) u_fill (
    .clk    (clk),
    .rst    (rst),
    .start  (cfg_fill_start),
    .ones   (cfg_fill_ones),
    .sel_in (cfg_wr_sel),
    .busy   (fill_busy),
    .sel    (fl_sel),
    .ptr    (fl_ptr),
    .data   (fl_data)
  );

  // ---------------- write port mux ----------------
  logic [PTR_W-1:0]  wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic              wr_sel;
  logic              wr_any;

  assign wr_addr = fill_busy ? fl_ptr  : cfg_wr_idx;
  assign wr_data = fill_busy ? fl_data : cfg_wr_data;
  assign wr_sel  = fill_busy ? fl_sel  : cfg_wr_sel;
  assign wr_any  = fill_busy | cfg_wr_en;

  // ---------------- tables ----------------
  logic [WORD_W-1:0] tbl_q [N_TABLES];

  for (genvar t = 0; t < N_TABLES; t++) begin : g_tbl
    logic we_t;
    assign we_t = wr_any && (wr_sel == 1'(t));
    mhf_table #(.WORDS(WORDS), .WORD_W(WORD_W)) u_tbl (
      .clk   (clk),
      .we    (we_t),
      .waddr (wr_addr),
      .wdata (wr_data),
      .re    (lk_valid),
      .raddr (rd_word),
      .rdata (tbl_q[t])
    );
  end

  // ---------------- lookup pipeline ----------------
  lk_ctx_t          ctx_q;
  logic [BIT_W-1:0] bit_q;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      ctx_q <= '0;
      bit_q <= '0;
    end else begin
      vld_q <= lk_valid;
      if (lk_valid) begin
        ctx_q.is_bc  <= &lk_addr;
        ctx_q.is_grp <= lk_addr[0];
        ctx_q.mc_en  <= cfg_mc_en;
        ctx_q.uc_en  <= cfg_uc_en;
        ctx_q.bc_acc <= cfg_bc_accept;
        bit_q        <= rd_bit;
      end
    end
  end

  // ---------------- decision ----------------
  logic mc_hit, uc_hit, pick;

  assign mc_hit = ctx_q.mc_en & tbl_q[TBL_MC][bit_q];
  assign uc_hit = ctx_q.uc_en & tbl_q[TBL_UC][bit_q];

  always_comb begin
    if (ctx_q.is_bc)       pick = ctx_q.bc_acc;
    else if (ctx_q.is_grp) pick = mc_hit;
    else                   pick = uc_hit;
  end

  assign res_valid     = vld_q;
  assign res_accept    = vld_q & pick;
  assign res_multicast = vld_q & ctx_q.is_grp;

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int WORDS = 128
) (
  input logic        clk,
  input logic        rst,
  input logic        cfg_mc_en,
  input logic        cfg_uc_en,
  input logic        cfg_bc_accept,
  input logic        cfg_fill_start,
  input logic        fill_busy,
  input logic        lk_valid,
  input logic [47:0] lk_addr,
  input logic        res_valid,
  input logic        res_accept,
  input logic        res_multicast
);

  int busy_len;

  always_ff @(posedge clk) begin
    if (rst) busy_len <= 0;
    else     busy_len <= fill_busy ? busy_len + 1 : 0;
  end

  AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid); // R6
  AST_ACCEPT_QUAL: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_accept); // R6
  AST_GROUP_FLAG: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_multicast == $past(lk_addr[0])); // R3
  AST_BCAST: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && (&lk_addr)) |=> res_accept == $past(cfg_bc_accept)); // R5
  AST_UC_OFF: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_addr[0] && !cfg_uc_en) |=> !res_accept); // R4
  AST_MC_OFF: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_addr[0] && !(&lk_addr) && !cfg_mc_en) |=> !res_accept); // R4
  AST_FILL_START: assert property (@(posedge clk) disable iff (rst)
    (cfg_fill_start && !fill_busy) |=> fill_busy); // R8
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_len <= WORDS); // R8

endmodule

bind mac_hash_filter mhf_checker #(.WORDS(WORDS)) u_mhf_checker (
  .clk            (clk),
  .rst            (rst),
  .cfg_mc_en      (cfg_mc_en),
  .cfg_uc_en      (cfg_uc_en),
  .cfg_bc_accept  (cfg_bc_accept),
  .cfg_fill_start (cfg_fill_start),
  .fill_busy      (fill_busy),
  .lk_valid       (lk_valid),
  .lk_addr        (lk_addr),
  .res_valid      (res_valid),
  .res_accept     (res_accept),
  .res_multicast  (res_multicast)
);

// File: tb/tb_mac_hash_filter.sv
module tb_mac_hash_filter;

  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_mc_en = 0, cfg_uc_en = 0, cfg_bc_accept = 0;
  logic        cfg_wr_en = 0, cfg_wr_sel = 0;
  logic [6:0]  cfg_wr_idx = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        cfg_fill_start = 0, cfg_fill_ones = 0;
  logic        fill_busy;
  logic        lk_valid = 0;
  logic [47:0] lk_addr = '0;
  logic        res_valid, res_accept, res_multicast;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_hash_filter dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_mc_en(cfg_mc_en),
    .cfg_uc_en(cfg_uc_en), .cfg_bc_accept(cfg_bc_accept),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_data(cfg_wr_data), .cfg_fill_start(cfg_fill_start),
    .cfg_fill_ones(cfg_fill_ones), .fill_busy(fill_busy),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_accept(res_accept), .res_multicast(res_multicast)
  );

  // ---------------- reference model ----------------
  bit    mc_ref [4096];
  bit    uc_ref [4096];
  bit    m_busy = 0, m_ones = 0, m_sel = 0;
  int    m_ptr = 0;
  bit    exp_valid = 0, exp_acc = 0, exp_mc = 0, exp_busy = 0;
  string cur_req = "R9";
  int    checks = 0, fails = 0, cyc = 0;

  function automatic int hidx(logic [47:0] a, logic [1:0] m);
    case (m)
      2'd0:    return int'(a[47:36]);
      2'd1:    return int'(a[46:35]);
      2'd2:    return int'(a[45:34]);
      default: return int'(a[43:32]);
    endcase
  endfunction

  function automatic void ref_write(bit sel, int w, logic [31:0] d);
    for (int b = 0; b < 32; b++) begin
      if (sel) uc_ref[w*32+b] = d[b];
      else     mc_ref[w*32+b] = d[b];
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      exp_valid = 0; exp_acc = 0; exp_mc = 0; m_busy = 0; exp_busy = 0;
    end else begin
      exp_valid = lk_valid;
      exp_mc    = lk_valid && lk_addr[0];
      exp_acc   = 0;
      if (lk_valid) begin
        if (&lk_addr)        exp_acc = cfg_bc_accept;
        else if (lk_addr[0]) exp_acc = cfg_mc_en && mc_ref[hidx(lk_addr, cfg_mode)];
        else                 exp_acc = cfg_uc_en && uc_ref[hidx(lk_addr, cfg_mode)];
      end
      if (m_busy) begin
        ref_write(m_sel, m_ptr, {32{m_ones}});
        m_ptr++;
        if (m_ptr == NWORDS) m_busy = 0;
      end else begin
        if (cfg_wr_en) ref_write(cfg_wr_sel, int'(cfg_wr_idx), cfg_wr_data);
        if (cfg_fill_start) begin
          m_busy = 1; m_ptr = 0; m_ones = cfg_fill_ones; m_sel = cfg_wr_sel;
        end
      end
      exp_busy = m_busy;
    end
  end

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", cur_req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc >= 2) begin
      chk("res_valid", res_valid, exp_valid);
      chk("res_accept", res_accept, exp_acc);
      chk("res_multicast", res_multicast, exp_mc);
      chk("fill_busy", fill_busy, exp_busy);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    cfg_wr_en = 0; cfg_fill_start = 0; lk_valid = 0;
  endtask

  task automatic fill(bit sel, bit ones);
    @(negedge clk);
    idle(); cfg_fill_start = 1; cfg_wr_sel = sel; cfg_fill_ones = ones;
    @(negedge clk); idle();
    repeat (NWORDS + 1) @(negedge clk);
  endtask

  task automatic wr(bit sel, int w, logic [31:0] d);
    @(negedge clk);
    idle(); cfg_wr_en = 1; cfg_wr_sel = sel; cfg_wr_idx = 7'(w); cfg_wr_data = d;
    @(negedge clk); idle();
  endtask

  // drive one lookup, return at the negedge where its result is visible
  task automatic look(logic [47:0] a, logic [1:0] m, bit exp_lit, string what);
    @(negedge clk);
    idle(); lk_valid = 1; lk_addr = a; cfg_mode = m;
    @(negedge clk); idle();
    chk(what, res_accept, exp_lit);
  endtask

  function automatic logic [47:0] rnd_addr();
    return {16'($urandom), $urandom};
  endfunction

  initial begin
    logic [47:0] a;
    int i;
    void'($urandom(7));
    // reset
    cur_req = "R9";
    repeat (4) @(negedge clk);
    chk("res_valid@reset", res_valid, 1'b0);
    chk("fill_busy@reset", fill_busy, 1'b0);
    chk("res_accept@reset", res_accept, 1'b0);
    rst = 0;

    cur_req = "R8";
    fill(0, 0);
    fill(1, 0);

    // window per mode
    cur_req = "R1";
    cfg_mc_en = 1; cfg_uc_en = 1;
    for (int m = 0; m < 4; m++) begin
      a = rnd_addr(); a[0] = 1; a[31:1] = '1; a[47:44] = 4'h5;
      i = hidx(a, 2'(m));
      wr(0, i >> 5, 32'h1 << (i & 31));
      look(a, 2'(m), 1'b1, "mode window hit");
      wr(0, i >> 5, 32'h0);
    end

    // word/bit split: index 0x0A3 -> word 5 bit 3, mode 3
    cur_req = "R2";
    wr(0, 5, 32'h0000_0008);
    look({4'h0, 12'h0A3, 32'h0000_0001}, 2'd3, 1'b1, "word5 bit3 hit");
    look({4'h0, 12'h0A4, 32'h0000_0001}, 2'd3, 1'b0, "word5 bit4 miss");
    look({4'h0, 12'h0C3, 32'h0000_0001}, 2'd3, 1'b0, "word6 bit3 miss");

    // group vs individual routing
    cur_req = "R3";
    wr(0, 5, 32'h0000_0008);
    wr(1, 5, 32'h0);
    look({4'h0, 12'h0A3, 32'h0000_0000}, 2'd3, 1'b0, "unicast uses uc table");
    look({4'h0, 12'h0A3, 32'h0000_0001}, 2'd3, 1'b1, "group uses mc table");

    // same-cycle write and lookup
    cur_req = "R7";
    @(negedge clk);
    idle(); cfg_wr_en = 1; cfg_wr_sel = 0; cfg_wr_idx = 7'd9; cfg_wr_data = '1;
    lk_valid = 1; lk_addr = {4'h0, 12'h120, 32'h1}; cfg_mode = 2'd3;
    @(negedge clk);
    chk("same-cycle old data", res_accept, 1'b0);
    idle(); lk_valid = 1;
    @(negedge clk); idle();
    chk("next-cycle new data", res_accept, 1'b1);

    // random traffic with per-cycle config changes
    cur_req = "R10";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      cfg_wr_en   = ($urandom % 2) == 0;
      cfg_wr_sel  = 1'($urandom);
      cfg_wr_idx  = 7'($urandom);
      cfg_wr_data = $urandom;
      lk_valid    = ($urandom % 4) != 0;
      a = rnd_addr();
      if ($urandom % 32 == 0) a = '1;
      lk_addr       = a;
      cfg_mode      = 2'($urandom);
      cfg_mc_en     = ($urandom % 4) != 0;
      cfg_uc_en     = ($urandom % 4) != 0;
      cfg_bc_accept = 1'($urandom);
    end
    idle();

    // disabled tables never hit
    cur_req = "R4";
    fill(0, 1);
    fill(1, 1);
    cfg_mc_en = 0; cfg_uc_en = 0;
    look(48'h1234_5678_9ABC, 2'd0, 1'b0, "uc disabled");
    look(48'h1234_5678_9ABD, 2'd1, 1'b0, "mc disabled");
    cfg_uc_en = 1;
    look(48'h1234_5678_9ABC, 2'd2, 1'b1, "uc all-ones enabled");

    // broadcast independent of mc table
    cur_req = "R5";
    cfg_mc_en = 1; cfg_bc_accept = 0;
    look('1, 2'd0, 1'b0, "bcast rejected with full mc table");
    fill(0, 0);
    cfg_mc_en = 0; cfg_bc_accept = 1;
    look('1, 2'd3, 1'b1, "bcast accepted with empty mc table");

    // back-to-back and gapped strobes
    cur_req = "R6";
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      lk_valid = (n % 3) != 2; lk_addr = rnd_addr(); cfg_mc_en = 1;
    end
    idle();

    // writes and fill pulses during a fill are dropped
    cur_req = "R8";
    @(negedge clk);
    idle(); cfg_fill_start = 1; cfg_wr_sel = 1; cfg_fill_ones = 0;
    @(negedge clk); idle();
    repeat (NWORDS - 2) begin
      @(negedge clk);
      cfg_wr_en = 1; cfg_wr_sel = 1; cfg_wr_idx = 7'd127; cfg_wr_data = '1;
      cfg_fill_start = 1; cfg_fill_ones = 1;
    end
    @(negedge clk); idle();
    repeat (4) @(negedge clk);
    cfg_uc_en = 1;
    look({4'h0, 12'hFFF, 32'h0}, 2'd3, 1'b0, "late word cleared by fill");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule